// File: doc/BRIEF.md
# Repeat and Loop Control Unit

This block sits beside an instruction sequencer. It does two jobs. The first is to make the single instruction that follows a repeat command run a counted number of times. The second is to keep track of how deeply hardware loops are nested.

A repeat is started with one of two counts:
- a 14-bit unsigned literal, or
- a 16-bit value taken from a working register.

In both cases the following instruction runs the count plus one times. While it is counting, the unit holds a re-issue request high. The sequencer then fetches the same instruction again instead of moving on. Each execution is reported back to the unit with a completion strobe.

Loop nesting is tracked with a 3-bit level, so up to seven loops can be active at once. The sequencer signals a loop entry when a loop begins and a loop exit when a loop's count runs out. Software can also write an early-termination request. That request ends the innermost loop at the next clock edge, which the sequencer presents at an iteration boundary. The request is write-only in effect: it leaves no stored bit behind.

Instruction fetch, the program counter and the storage of loop addresses all belong to the sequencer, not to this unit. All outputs are registered, and reset is synchronous and active high.

Top module: `rptloop_ctrl`

## Requirements
- R1: After a literal-count start with value N (0 to 16383, zero-extended), the repeat ends on the (N+1)th completion strobe: `rpt_active` is 0 from the cycle after that strobe.
- R2: After a register-count start with value N (0 to 65535), the repeat ends on the (N+1)th completion strobe.
- R3: `rpt_active` goes to 1 in the cycle after an accepted start and stays 1 until the cycle after the final strobe.
- R4: `reissue` is 1 exactly while `rpt_active` is 1 and strobes are still owed beyond the next one (remaining count nonzero). A count of 0 never raises `reissue`.
- R5: The following starts and strobes are ignored:
  - a start while `rpt_active` is 1;
  - a completion strobe while `rpt_active` is 0.

  If the literal and register starts come together, the literal count is used.
- R6: Each loop entry raises `nest_level` by one, and the level stays within 0 to 7.
- R7: A loop entry at level 7 (with no decrement in the same cycle) leaves the level at 7. It raises `nest_err` for one cycle per such entry.
- R8: A loop exit lowers `nest_level` by one. An exit at level 0 is ignored.
- R9: An early-termination request lowers `nest_level` by one at the next edge and has no effect at level 0. A request together with an exit gives a single decrement.
- R10: `loop_active` is 1 exactly when `nest_level` is nonzero.
- R11: After reset, all of the following read 0: `rpt_active`, `reissue`, `loop_active`, `nest_level` and `nest_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_go_lit | input | 1 | Start a repeat with the literal count |
| rpt_lit | input | 14 | Literal repeat count |
| rpt_go_reg | input | 1 | Start a repeat with the register count |
| rpt_reg | input | 16 | Register repeat count |
| instr_done | input | 1 | One execution of the repeated instruction completed |
| loop_enter | input | 1 | A hardware loop begins |
| loop_exit | input | 1 | The innermost loop finished its count |
| loop_abort | input | 1 | Early-termination request for the innermost loop |
| rpt_active | output | 1 | Repeat in progress |
| reissue | output | 1 | Fetch the current instruction again |
| loop_active | output | 1 | At least one loop is active |
| nest_level | output | 3 | Number of active loops |
| nest_err | output | 1 | Entry refused because nesting is full |

## Verification
The bench goes after three groups of corner cases, each tied to the failure it would expose:
- Count extremes. It runs a zero count, the full 16383 literal and the full 65535 register count. A counter that ran N rather than N+1 times, or that truncated the register count, would end the repeat one strobe early or thousands of strobes early.
- Simultaneous inputs. It drives a start while a repeat is already running, both start kinds at once, and strobes while idle. A design that reloaded, picked the register count, or counted stray strobes would show a wrong `rpt_active` or `reissue`.
- Nesting limits. It drives an entry at level 7, exits and aborts at level 0, and an abort together with an exit. A design that wrapped the level, went below zero or decremented twice would show a wrong `nest_level`.

// File: rtl/rptloop_pkg.sv
package rptloop_pkg;

  typedef enum logic [1:0] {
    NEST_HOLD  = 2'd0,
    NEST_UP    = 2'd1,
    NEST_DOWN  = 2'd2,
    NEST_BLOCK = 2'd3
  } nest_op_e;

  function automatic nest_op_e pick_nest_op(input logic up, input logic down,
                                            input logic at_top, input logic at_bottom);
    logic dec;
    dec = down && !at_bottom;
    if (up && dec)         return NEST_HOLD;
    else if (dec)          return NEST_DOWN;
    else if (up && at_top) return NEST_BLOCK;
    else if (up)           return NEST_UP;
    else                   return NEST_HOLD;
  endfunction

endpackage

// File: rtl/rpt_counter.sv
module rpt_counter #(
  parameter int LIT_W = 14,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_lit,
  input  logic [LIT_W-1:0] lit_val,
  input  logic             start_reg,
  input  logic [REG_W-1:0] reg_val,
  input  logic             step,
  output logic             active_o,
  output logic             reissue_o
);
  localparam int CNT_W = (LIT_W > REG_W) ? LIT_W : REG_W;

  logic [CNT_W-1:0] rem_q, rem_d;
  logic             act_q, act_d;
  logic             reis_q;

  always_comb begin
    act_d = act_q;
    rem_d = rem_q;
    if (!act_q && start_lit) begin
      act_d = 1'b1;
      rem_d = CNT_W'(lit_val);
    end else if (!act_q && start_reg) begin
      act_d = 1'b1;
      rem_d = CNT_W'(reg_val);
    end else if (act_q && step) begin
      if (rem_q == '0) act_d = 1'b0;
      else             rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      rem_q  <= '0;
      reis_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      rem_q  <= rem_d;
      reis_q <= act_d && (rem_d != '0);
    end
  end

  assign active_o  = act_q;
  assign reissue_o = reis_q;

  AST_REM_STEPS: assert property (@(posedge clk) disable iff (rst)
    (act_q && step && rem_q != '0) |=> (act_q && rem_q == $past(rem_q) - 1'b1)); // R1
  AST_LAST_STEP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (act_q && step && rem_q == '0) |=> !act_q); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (act_q && (start_lit || start_reg) && !step) |=> (act_q && $stable(rem_q))); // R5
  AST_REISSUE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    reis_q |-> act_q); // R4

endmodule

// File: rtl/loop_nest.sv
module loop_nest
  import rptloop_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter,
  input  logic             leave,
  input  logic             abort,
  output logic [LVL_W-1:0] level_o,
  output logic             active_o,
  output logic             err_o
);
  localparam logic [LVL_W-1:0] MAX_LVL = {LVL_W{1'b1}};

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             act_q, err_q;
  nest_op_e         op;

  always_comb begin
    op    = pick_nest_op(enter, leave || abort, lvl_q == MAX_LVL, lvl_q == '0);
    lvl_d = lvl_q;
    case (op)
      NEST_UP:   lvl_d = lvl_q + 1'b1;
      NEST_DOWN: lvl_d = lvl_q - 1'b1;
      default:   lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      act_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      act_q <= (lvl_d != '0);
      err_q <= (op == NEST_BLOCK);
    end
  end

  assign level_o  = lvl_q;
  assign active_o = act_q;
  assign err_o    = err_q;

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
    (lvl_q == MAX_LVL && enter && !leave && !abort) |=> (lvl_q == MAX_LVL && err_q)); // R7
  AST_ERR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(lvl_q) == MAX_LVL); // R7
  AST_EXIT_DEC: assert property (@(posedge clk) disable iff (rst)
    ((leave || abort) && !enter && lvl_q != '0) |=> lvl_q == $past(lvl_q) - 1'b1); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (lvl_q == '0 && !enter) |=> lvl_q == '0); // R8
  AST_ACTIVE_MATCH: assert property (@(posedge clk) disable iff (rst)
    act_q == (lvl_q != '0)); // R10

endmodule

// File: rtl/rptloop_ctrl.sv
module rptloop_ctrl #(
  parameter int LIT_W = 14,
  parameter int REG_W = 16,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rpt_go_lit,
  input  logic [LIT_W-1:0] rpt_lit,
  input  logic             rpt_go_reg,
  input  logic [REG_W-1:0] rpt_reg,
  input  logic             instr_done,
  input  logic             loop_enter,
  input  logic             loop_exit,
  input  logic             loop_abort,
  output logic             rpt_active,
  output logic             reissue,
  output logic             loop_active,
  output logic [LVL_W-1:0] nest_level,
  output logic             nest_err
);

  rpt_counter #(.LIT_W(LIT_W), .REG_W(REG_W)) u_rpt (
    .clk       (clk),
    .rst       (rst),
    .start_lit (rpt_go_lit),
    .lit_val   (rpt_lit),
    .start_reg (rpt_go_reg),
    .reg_val   (rpt_reg),
    .step      (instr_done),
    .active_o  (rpt_active),
    .reissue_o (reissue)
  );

  loop_nest #(.LVL_W(LVL_W)) u_nest (
    .clk      (clk),
    .rst      (rst),
    .enter    (loop_enter),
    .leave    (loop_exit),
    .abort    (loop_abort),
    .level_o  (nest_level),
    .active_o (loop_active),
    .err_o    (nest_err)
  );

  AST_IDLE_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
    (!rpt_active && !rpt_go_lit && !rpt_go_reg) |=> !reissue); // R5

endmodule

// File: tb/rptloop_ctrl_test.sv
`timescale 1ns/1ps
module rptloop_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        go_lit, go_reg, done, en, ex, ab;
  logic [13:0] lit;
  logic [15:0] regv;
  logic        rpt_active, reissue, loop_active, nest_err;
  logic [2:0]  nest_level;

  int checks = 0;
  int errors = 0;

  bit          m_act;
  int unsigned m_rem;
  int          m_lvl;
  bit          m_err;

  always #2 clk = ~clk;

  rptloop_ctrl uut (
    .clk(clk), .rst(rst), .rpt_go_lit(go_lit), .rpt_lit(lit), .rpt_go_reg(go_reg),
    .rpt_reg(regv), .instr_done(done), .loop_enter(en), .loop_exit(ex), .loop_abort(ab),
    .rpt_active(rpt_active), .reissue(reissue), .loop_active(loop_active),
    .nest_level(nest_level), .nest_err(nest_err)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit exp_reissue();
    return m_act && (m_rem != 0);
  endfunction

  task automatic model_step(input bit sl, input int unsigned lv, input bit sr,
                            input int unsigned rv, input bit dn, input bit e,
                            input bit x, input bit a);
    bit dec;
    if (!m_act && sl)      begin m_act = 1; m_rem = lv; end
    else if (!m_act && sr) begin m_act = 1; m_rem = rv; end
    else if (m_act && dn)  begin if (m_rem == 0) m_act = 0; else m_rem = m_rem - 1; end
    dec   = (x || a) && (m_lvl != 0);
    m_err = e && !dec && (m_lvl == 7);
    if (dec) m_lvl = m_lvl - 1;
    if (e && !(m_lvl == 7 && !dec)) m_lvl = m_lvl + 1;
  endtask

  task automatic step(input bit sl, input int unsigned lv, input bit sr,
                      input int unsigned rv, input bit dn, input bit e,
                      input bit x, input bit a);
    @(negedge clk);
    go_lit = sl; lit = lv[13:0]; go_reg = sr; regv = rv[15:0];
    done = dn; en = e; ex = x; ab = a;
    @(posedge clk);
    model_step(sl, lv, sr, rv, dn, e, x, a);
    #1;
    chk("R3 rpt_active", rpt_active, m_act);
    chk("R4 reissue", reissue, exp_reissue());
    chk("R6 nest_level", nest_level, m_lvl);
    chk("R10 loop_active", loop_active, m_lvl != 0);
    chk("R7 nest_err", nest_err, m_err);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; go_lit = 0; go_reg = 0; lit = '0; regv = '0;
    done = 0; en = 0; ex = 0; ab = 0;
    m_act = 0; m_rem = 0; m_lvl = 0; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R11 rpt_active", rpt_active, 0);
    chk("R11 reissue", reissue, 0);
    chk("R11 nest_level", nest_level, 0);
    chk("R11 loop_active", loop_active, 0);
    chk("R11 nest_err", nest_err, 0);

    // R5: strobe while idle is ignored
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R5 idle strobe", rpt_active, 0);

    // R4: zero count runs once, no reissue
    step(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 zero count reissue", reissue, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R1 zero count ends", rpt_active, 0);

    // R1: full literal count
    step(1, 16383, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16383; i++) step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R1 still active before last", rpt_active, 1);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R1 ends after 16384 strobes", rpt_active, 0);

    // R2: full register count
    step(0, 0, 1, 65535, 0, 0, 0, 0);
    for (int i = 0; i < 65535; i++) step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R2 still active before last", rpt_active, 1);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R2 ends after 65536 strobes", rpt_active, 0);

    // R5: literal wins over register; start while active ignored
    step(1, 1, 1, 9, 0, 0, 0, 0);
    step(0, 0, 1, 50, 1, 0, 0, 0);
    step(1, 40, 0, 0, 1, 0, 0, 0);
    chk("R5 literal priority / start ignored", rpt_active, 0);

    // Nesting corners
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 level reaches 7", nest_level, 7);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 full entry err", nest_err, 1);
    chk("R7 full entry level", nest_level, 7);
    idle();
    chk("R7 err one cycle", nest_err, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 exit decrements", nest_level, 6);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 abort decrements", nest_level, 5);
    step(0, 0, 0, 0, 0, 0, 1, 1);
    chk("R9 abort with exit single dec", nest_level, 4);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 exit at zero ignored", nest_level, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 abort at zero ignored", nest_level, 0);
    chk("R10 inactive at zero", loop_active, 0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      int unsigned lv, rv;
      r  = $urandom % 100;
      lv = ($urandom % 10 == 0) ? ($urandom % 300) : ($urandom % 6);
      rv = ($urandom % 10 == 0) ? ($urandom % 500) : ($urandom % 6);
      step(r < 4, lv, (r >= 4 && r < 8) || (r == 2), rv, ($urandom % 2) == 1,
           ($urandom % 100) < 20, ($urandom % 100) < 10, ($urandom % 100) < 6);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule